// File: doc/BRIEF.md
# Serial Flash Slave Bit Interface

This block is the bit-level front end of a serial flash slave. It watches the four serial pins (clock, data in, active-low select and active-low pause) on a fast system clock. Input bits are taken on rising serial-clock edges and packed into bytes, most significant bit first. Each finished byte goes to a command engine with a one-cycle strobe. In the other direction the engine offers a byte through a valid/take handshake. The block sends that byte out on the serial output, one bit per falling serial-clock edge. If the engine offers nothing, the block sends all ones.

Both serial clock polarities work: idle low (mode 0) and idle high (mode 3). A bit is launched only after the rising edge that captured the previous bit, so the extra falling edge at the start of a mode-3 frame moves nothing. Once reset ends, all serial traffic is ignored until select has been seen going low. A pause request stops shifting in the middle of a byte and turns the output driver off, without ending the frame. When the pause ends, shifting continues from the bit where it stopped.

All pins pass through a synchronizer. The serial clock must therefore run well below the system clock.

Top module: `sflash_serial_frontend`

## Requirements
- R1: Each rising serial-clock edge while selected and not paused captures `sdi`, MSB first. After the 8th capture of a byte, `rx_valid` pulses for one cycle with the byte on `rx_data`.
- R2: `sdo` changes only after a falling serial-clock edge that follows a capture, or when a byte is loaded. The MSB of a loaded byte is on `sdo` before the first rising edge that belongs to that byte.
- R3: While `csn` is high, `sdo_oe` is 0. While selected and not paused, `sdo_oe` is 1.
- R4: After reset, nothing is received, no output is driven and no frame indication is raised until a high-to-low transition of `csn` has been seen. A `csn` that is already low when reset ends does not count as that transition.
- R5: A pause begins when `holdn` falls while the device is selected. During a pause, `sdo_oe` is 0 and serial-clock and `sdi` activity is ignored. When `holdn` rises again, the bit count continues exactly where it stopped.
- R6: A `holdn` fall while `csn` is high starts no pause. If `holdn` is still low when `csn` falls, the frame works normally.
- R7: In mode 3, with the serial clock idle high, reception and transmission give the same results as in mode 0.
- R8: A `csn` rising edge discards any partial byte and drops any pending output bit. `frame_close` pulses for one cycle, and the next frame starts counting at bit 0.
- R9: A byte is loaded for transmission at each `csn` fall and on the falling edge after each 8th capture. If `tx_valid` is 1 at that moment, `tx_data` is loaded and `tx_take` pulses. Otherwise 0xFF is sent and `tx_take` stays 0.
- R10: `frame_open` pulses for exactly one cycle on each accepted `csn` fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| csn | input | 1 | Active-low select |
| holdn | input | 1 | Active-low pause request |
| tx_data | input | 8 | Next byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_take | output | 1 | Offered byte was loaded this cycle |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` is new |
| frame_open | output | 1 | One-cycle pulse when a frame starts |
| frame_close | output | 1 | One-cycle pulse when a frame ends |

## Verification
The bench sends every byte value through one long frame in each clock polarity, and checks the transmitted stream across every byte boundary. A wrong reload point would shift the transmitted bytes by one bit. In mode 3, a design that launches on the first falling edge would lose the MSB.

A burst is clocked with select held low from reset. A design that arms on the select level instead of the select fall would receive that burst.

Other cases cover:
- A partial byte cut off by deselection. A design that keeps the count would misalign the next frame.
- A pause with serial-clock toggles in the middle of a byte. A design that lets those toggles through would receive extra bits.
- A pause request made while deselected. A design that latches it would keep the output off.
- A frame with no byte offered. A design that forgets the fill value would send stale data.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0]    byte_t;
    typedef logic [BIT_IDX_W-1:0] bit_idx_t;

    localparam byte_t    IDLE_FILL = '1;
    localparam bit_idx_t LAST_BIT  = bit_idx_t'(BYTE_W - 1);

    // synchronized pin bundle
    typedef struct packed {
        logic sck;
        logic sdi;
        logic csn;
        logic holdn;
    } pins_t;

    // single-cycle events derived from the synchronized pins
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic hold_fall;
        logic hold_rise;
        logic sck_rise;
        logic sck_fall;
    } evt_t;

    function automatic byte_t push_bit(byte_t cur, logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
    import sfe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     rise,
    input  logic     sdi_s,
    output byte_t    rx_data,
    output logic     rx_valid,
    output bit_idx_t bit_cnt
);
    byte_t shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (clr) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg   <= push_bit(shreg, sdi_s);
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    rx_valid <= 1'b1;
                    rx_data  <= push_bit(shreg, sdi_s);
                end
            end
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R1
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
    import sfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  abort,
    input  logic  rise,
    input  logic  fall,
    input  logic  last,
    input  byte_t tx_data,
    input  logic  tx_valid,
    output logic  tx_take,
    output logic  sdo
);
    byte_t shreg;
    logic  pend;     // a capture happened, next fall launches
    logic  reload;   // that capture closed a byte

    logic load_now, shift_now;
    assign load_now  = start || (fall && pend && reload);
    assign shift_now = fall && pend && !reload;
    assign tx_take   = load_now && tx_valid;
    assign sdo       = shreg[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= IDLE_FILL;
            pend   <= 1'b0;
            reload <= 1'b0;
        end else begin
            if (abort || start) begin
                pend   <= 1'b0;
                reload <= 1'b0;
            end else if (rise) begin
                pend   <= 1'b1;
                reload <= last;
            end else if (fall) begin
                pend   <= 1'b0;
            end
            if (load_now)
                shreg <= tx_valid ? tx_data : IDLE_FILL;
            else if (shift_now)
                shreg <= push_bit(shreg, 1'b1);
        end
    end

    AST_SDO_ONLY_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!fall && !start) |=> $stable(sdo)); // R2
    AST_NO_LAUNCH_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (fall && !pend && !start) |=> $stable(sdo)); // R7
endmodule

// File: rtl/sflash_serial_frontend.sv
module sflash_serial_frontend
    import sfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_in,
    input  logic       sdi,
    input  logic       csn,
    input  logic       holdn,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_take,
    output logic       sdo,
    output logic       sdo_oe,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       frame_open,
    output logic       frame_close
);
    localparam int PIN_W = $bits(pins_t);

    pins_t    raw, s;
    evt_t     ev;
    logic     p_sck, p_csn, p_hold;
    logic     armed, hold_q, sel, active;
    bit_idx_t bit_cnt;
    logic     last;

    assign raw = '{sck: sck_in, sdi: sdi, csn: csn, holdn: holdn};

    sfe_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (s)
    );

    // previous levels; reset low so a select held low through reset is no edge
    always_ff @(posedge clk) begin
        if (rst) begin
            p_sck  <= 1'b0;
            p_csn  <= 1'b0;
            p_hold <= 1'b0;
        end else begin
            p_sck  <= s.sck;
            p_csn  <= s.csn;
            p_hold <= s.holdn;
        end
    end

    assign sel    = armed && !s.csn;
    assign active = sel && !hold_q;

    always_comb begin
        ev.cs_fall   = p_csn && !s.csn;
        ev.cs_rise   = !p_csn && s.csn;
        ev.hold_fall = p_hold && !s.holdn;
        ev.hold_rise = !p_hold && s.holdn;
        ev.sck_rise  = active && !p_sck && s.sck;
        ev.sck_fall  = active && p_sck && !s.sck;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (ev.cs_fall) armed <= 1'b1;
            if (s.csn)
                hold_q <= 1'b0;
            else if (sel && ev.hold_fall)
                hold_q <= 1'b1;
            else if (ev.hold_rise)
                hold_q <= 1'b0;
        end
    end

    assign frame_open  = ev.cs_fall;
    assign frame_close = ev.cs_rise && armed;
    assign sdo_oe      = active;
    assign last        = ev.sck_rise && (bit_cnt == LAST_BIT);

    sfe_rx i_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (ev.cs_fall || ev.cs_rise),
        .rise     (ev.sck_rise),
        .sdi_s    (s.sdi),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .bit_cnt  (bit_cnt)
    );

    sfe_tx i_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (ev.cs_fall),
        .abort    (ev.cs_rise),
        .rise     (ev.sck_rise),
        .fall     (ev.sck_fall),
        .last     (last),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_take  (tx_take),
        .sdo      (sdo)
    );

    AST_RX_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> armed); // R4
    AST_HOLD_FREEZES_COUNT: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !ev.cs_rise) |=> $stable(bit_cnt)); // R5
    AST_HOLD_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_q) |-> $past(sel)); // R6
    AST_CLOSE_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        frame_close |-> !sdo_oe); // R3
    AST_CLOSE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        frame_close |=> (bit_cnt == '0)); // R8
    AST_OPEN_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_open |=> !frame_open); // R10
endmodule

// File: tb/test_sflash_serial_frontend.sv
`timescale 1ns/1ps
module test_sflash_serial_frontend;
    localparam int HALF  = 8;
    localparam int LIMIT = 200000;

    logic       clk = 1'b0;
    logic       rst, sck_in, sdi, csn, holdn, tx_valid;
    logic [7:0] tx_data;
    logic       tx_take, sdo, sdo_oe, rx_valid, frame_open, frame_close;
    logic [7:0] rx_data;

    int n_chk = 0, n_fail = 0;
    int rx_cnt = 0, fo_cnt = 0, fc_cnt = 0, tk_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sflash_serial_frontend i_sflash_serial_frontend (
        .clk(clk), .rst(rst), .sck_in(sck_in), .sdi(sdi), .csn(csn), .holdn(holdn),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_open(frame_open), .frame_close(frame_close)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
            if (frame_open)  fo_cnt++;
            if (frame_close) fc_cnt++;
            if (tx_take)     tk_cnt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_hold;
        holdn = 1'b0;
        tick(HALF);
        chk(sdo_oe == 1'b0, "R5", "oe during pause", sdo_oe, 0);
        for (int k = 0; k < 3; k++) begin
            sck_in = 1'b1; sdi = ~sdi;
            tick(HALF);
            sck_in = 1'b0;
            tick(HALF);
        end
        holdn = 1'b1;
        tick(HALF);
        chk(sdo_oe == 1'b1, "R5", "oe after pause", sdo_oe, 1);
    endtask

    task automatic xfer(input bit m3, input logic [7:0] mosi, input logic [7:0] exp,
                        input int nbits, input logic [7:0] nxt, input bit nval,
                        input int hold_at, input string req);
        logic [7:0] miso = 8'h00;
        int rc0 = rx_cnt;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (m3) sck_in = 1'b0;
            sdi = mosi[i];
            tick(HALF);
            miso[i] = sdo;
            sck_in = 1'b1;
            if (i == 0) begin tx_data = nxt; tx_valid = nval; end
            tick(HALF);
            if (!m3) sck_in = 1'b0;
            if (i == hold_at) do_hold();
        end
        if (nbits == 8) begin
            tick(HALF);
            chk(rx_cnt == rc0 + 1, "R1", "strobe count", rx_cnt - rc0, 1);
            chk(rx_last == mosi, "R1", "received byte", rx_last, mosi);
            chk(miso == exp, req, "sent byte", miso, exp);
        end
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int fc0, rc0, tk0;
        rst = 1'b1; csn = 1'b0; holdn = 1'b1; sck_in = 1'b0; sdi = 1'b0;
        tx_valid = 1'b0; tx_data = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(4);
        chk(sdo_oe == 1'b0, "R4", "reset oe", sdo_oe, 0);
        chk(fo_cnt == 0, "R4", "reset frame_open", fo_cnt, 0);

        // select low since reset: traffic must be ignored
        xfer(1'b0, 8'hA5, 8'h00, 7, 8'h00, 1'b0, -1, "R4");
        sdi = 1'b1; tick(HALF); sck_in = 1'b1; tick(HALF); sck_in = 1'b0; tick(HALF);
        chk(rx_cnt == 0, "R4", "unarmed strobes", rx_cnt, 0);
        chk(sdo_oe == 1'b0, "R4", "unarmed oe", sdo_oe, 0);
        csn = 1'b1; tick(HALF);
        chk(fc_cnt == 0, "R4", "unarmed close", fc_cnt, 0);

        // mode 0 sweep over all byte values in one frame
        tx_data = 8'h5A; tx_valid = 1'b1;
        csn = 1'b0; tick(HALF);
        chk(fo_cnt == 1, "R10", "open count", fo_cnt, 1);
        chk(tk_cnt == 1, "R9", "take at start", tk_cnt, 1);
        chk(sdo_oe == 1'b1, "R3", "oe selected", sdo_oe, 1);
        for (int v = 0; v < 256; v++)
            xfer(1'b0, 8'(v), 8'(v) ^ 8'h5A, 8, 8'(v + 1) ^ 8'h5A, 1'b1, -1, "R2");
        chk(tk_cnt == 257, "R9", "take count", tk_cnt, 257);
        csn = 1'b1; tick(HALF);
        chk(sdo_oe == 1'b0, "R3", "oe deselected", sdo_oe, 0);
        chk(fc_cnt == 1, "R8", "close count", fc_cnt, 1);

        // nothing offered: all ones
        tx_valid = 1'b0; tk0 = tk_cnt;
        csn = 1'b0; tick(HALF);
        xfer(1'b0, 8'h3C, 8'hFF, 8, 8'h12, 1'b0, -1, "R9");
        xfer(1'b0, 8'hC7, 8'hFF, 8, 8'h12, 1'b0, -1, "R9");
        chk(tk_cnt == tk0, "R9", "no take without valid", tk_cnt - tk0, 0);
        csn = 1'b1; tick(HALF);

        // abort a partial byte
        tx_data = 8'hC3; tx_valid = 1'b1;
        csn = 1'b0; tick(HALF);
        fc0 = fc_cnt; rc0 = rx_cnt;
        xfer(1'b0, 8'hE0, 8'h00, 3, 8'hC3, 1'b1, -1, "R8");
        csn = 1'b1; tick(HALF);
        chk(fc_cnt == fc0 + 1, "R8", "close on abort", fc_cnt - fc0, 1);
        chk(rx_cnt == rc0, "R8", "partial byte dropped", rx_cnt - rc0, 0);
        csn = 1'b0; tick(HALF);
        xfer(1'b0, 8'h96, 8'hC3, 8, 8'h2D, 1'b1, -1, "R8");

        // pause mid-byte
        xfer(1'b0, 8'h6B, 8'h2D, 8, 8'h00, 1'b1, 4, "R5");
        csn = 1'b1; tick(HALF);

        // pause request while deselected
        holdn = 1'b0; tick(HALF);
        tx_data = 8'hE1; tx_valid = 1'b1;
        csn = 1'b0; tick(HALF);
        chk(sdo_oe == 1'b1, "R6", "oe with early hold low", sdo_oe, 1);
        xfer(1'b0, 8'h71, 8'hE1, 8, 8'h00, 1'b1, -1, "R6");
        csn = 1'b1; holdn = 1'b1; tick(HALF);

        // mode 3 sweep
        sck_in = 1'b1; tick(HALF);
        tx_data = 8'hA5; tx_valid = 1'b1;
        csn = 1'b0; tick(HALF);
        for (int v = 0; v < 256; v++)
            xfer(1'b1, 8'(255 - v), 8'(v) ^ 8'hA5, 8, 8'(v + 1) ^ 8'hA5, 1'b1, -1, "R7");
        csn = 1'b1; tick(HALF);
        sck_in = 1'b0; tick(HALF);
        chk(fo_cnt == 6, "R10", "total opens", fo_cnt, 6);
        chk(fc_cnt == 6, "R8", "total closes", fc_cnt, 6);
        report();
    end
endmodule